// File: doc/BRIEF.md
# Parallel Port Pack/Unpack Buffer

This block is the data path of an external parallel port. It sits between a 32-bit internal word bus and an external data bus that is 8 or 16 bits wide. On the receive side it builds a 32-bit word from successive bus transfers. When the last piece of a word arrives, it presents the finished word to the internal side with a one-cycle valid pulse.

On the transmit side, a core or DMA write loads a holding register. The word then moves into an output register, which drives the external bus one piece at a time under a valid/ready handshake. Both directions work least significant piece first. When the output register finishes a word and the holding register is occupied, the output register refills from the holding register on the same clock edge. The external stream therefore has no gap between words.

A bus-width select chooses between 8-bit and 16-bit pieces. Transmit writes are accepted only while the transmit-direction enable is high. Any change of either setting flushes the block.

Top module: `pport_pack_buffer`

## Requirements
- R1: With busWide=0, four rxValid transfers form one word. The first supplies rxData[7:0] as word bits 7:0, the second as bits 15:8, the third as bits 23:16 and the fourth as bits 31:24.
- R2: With busWide=1, two rxValid transfers form one word. The first supplies rxData[15:0] as bits 15:0 and the second as bits 31:16.
- R3: rdValid is high for exactly one cycle, in the cycle after the final piece is taken, with rdData holding the word. The next transfer starts a new word at the least significant piece.
- R4: With busWide=0, a word is sent as four txData pieces. The pieces are bits 7:0, 15:8, 23:16 and 31:24 in that order, in txData[7:0], with txData[15:8] zero.
- R5: With busWide=1, a word is sent as two txData pieces: bits 15:0 first, then bits 31:16.
- R6: While txValid is high and txReady is low, txData and txValid hold their values.
- R7: A word written while both stages are empty is in the holding register one cycle after acceptance (holdEmpty=0, outEmpty=1). One cycle later it is in the output register (holdEmpty=1, outEmpty=0, txValid=1).
- R8: While the holding register is full, wrReady is low. A stalled write is accepted later and is never lost.
- R9: When the last piece of a word is taken and the holding register is full, the held word becomes the output on the next cycle. Back-to-back words stream with no idle cycle.
- R10: While txEnable is 0, wrReady is 0 and writes have no effect: both stages stay empty and txValid stays 0.
- R11: A change of busWide or txEnable clears both transmit stages, the piece counters and the receive packer. In the cycle of the change, wrReady is 0 and inputs are ignored.
- R12: After reset, holdEmpty=1, outEmpty=1, txValid=0, rdValid=0 and wrReady=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWide | input | 1 | 0: 8-bit bus pieces, 1: 16-bit bus pieces |
| txEnable | input | 1 | Transmit-direction enable; writes accepted only when 1 |
| wrValid | input | 1 | Internal write request |
| wrData | input | 32 | Internal write word |
| wrReady | output | 1 | Holding register can accept a word |
| txValid | output | 1 | A transmit piece is on txData |
| txData | output | 16 | Transmit piece (8-bit mode uses bits 7:0) |
| txReady | input | 1 | External side takes the piece |
| rxValid | input | 1 | A receive piece is on rxData |
| rxData | input | 16 | Receive piece (8-bit mode uses bits 7:0) |
| rdValid | output | 1 | One-cycle pulse: packed word available |
| rdData | output | 32 | Packed receive word |
| holdEmpty | output | 1 | Holding register is empty |
| outEmpty | output | 1 | Output register is empty |

## Verification
The embedded assertions check a set of cycle properties on every cycle:
- wrReady stays low while the holding register is occupied.
- rdValid never lasts two cycles.
- a waiting transmit piece stays stable.
- a held word moves into an idle output register on the next edge.
- the 16-bit piece counter stays in range.
- a disabled transmit direction keeps both stages empty.

Only the bench scenarios can show the piece ordering in both widths, the word values that come out of packing and unpacking, gap-free streaming across three queued words, and the flush of partial state on a width change.

// File: rtl/pport_pkg.sv
package pport_pkg;

  // Strobes from the control to the datapath for one clock.
  typedef struct packed {
    logic clear;     // flush all data registers
    logic loadHold;  // capture wrData into the holding register
    logic moveOut;   // move the holding word into the output register
    logic rxLoad;    // merge one receive piece into the packer
    logic rxDone;    // last piece: publish the packed word
  } strobes_t;

endpackage

// File: rtl/pport_ctrl.sv
module pport_ctrl
  import pport_pkg::*;
#(
  parameter int NARROW_PIECES = 4,
  parameter int WIDE_PIECES   = 2,
  parameter int CNT_W         = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             busWide,
  input  logic             txEnable,
  input  logic             wrValid,
  input  logic             txReady,
  input  logic             rxValid,
  output logic             wrReady,
  output logic             txValid,
  output logic             rdValid,
  output logic             holdEmpty,
  output logic             outEmpty,
  output logic [CNT_W-1:0] txIdx,
  output logic [CNT_W-1:0] rxIdx,
  output strobes_t         strobe
);

  localparam logic [CNT_W-1:0] NARROW_LAST = CNT_W'(NARROW_PIECES - 1);
  localparam logic [CNT_W-1:0] WIDE_LAST   = CNT_W'(WIDE_PIECES - 1);

  logic             prevWide, prevEn;
  logic             holdFull, outFull;
  logic [CNT_W-1:0] txCnt, rxCnt;
  logic             cfgChange, lastTx, lastRx;
  logic             txFire, txLastFire;

  assign cfgChange  = (busWide != prevWide) || (txEnable != prevEn);
  assign lastTx     = (txCnt == (busWide ? WIDE_LAST : NARROW_LAST));
  assign lastRx     = (rxCnt == (busWide ? WIDE_LAST : NARROW_LAST));

  assign wrReady    = txEnable && !holdFull && !cfgChange;
  assign txValid    = outFull;
  assign txFire     = outFull && txReady && !cfgChange;
  assign txLastFire = txFire && lastTx;

  always_comb begin
    strobe          = '0;
    strobe.clear    = cfgChange;
    strobe.loadHold = wrValid && wrReady;
    strobe.moveOut  = holdFull && (!outFull || txLastFire) && !cfgChange;
    strobe.rxLoad   = rxValid && !cfgChange;
    strobe.rxDone   = rxValid && !cfgChange && lastRx;
  end

  assign holdEmpty = !holdFull;
  assign outEmpty  = !outFull;
  assign txIdx     = txCnt;
  assign rxIdx     = rxCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevWide <= 1'b0;
      prevEn   <= 1'b0;
      holdFull <= 1'b0;
      outFull  <= 1'b0;
      txCnt    <= '0;
      rxCnt    <= '0;
      rdValid  <= 1'b0;
    end else begin
      prevWide <= busWide;
      prevEn   <= txEnable;
      if (cfgChange) begin
        holdFull <= 1'b0;
        outFull  <= 1'b0;
        txCnt    <= '0;
        rxCnt    <= '0;
        rdValid  <= 1'b0;
      end else begin
        if (strobe.loadHold)     holdFull <= 1'b1;
        else if (strobe.moveOut) holdFull <= 1'b0;

        if (strobe.moveOut)      outFull <= 1'b1;
        else if (txLastFire)     outFull <= 1'b0;

        if (txLastFire)          txCnt <= '0;
        else if (txFire)         txCnt <= txCnt + 1'b1;

        if (strobe.rxDone)       rxCnt <= '0;
        else if (strobe.rxLoad)  rxCnt <= rxCnt + 1'b1;

        rdValid <= strobe.rxDone;
      end
    end
  end

  // A held word with an idle output stage moves across on the next edge.
  AST_REFILL_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (holdFull && !outFull && !cfgChange) |=> (outFull && !holdFull)); // R7

  // In 16-bit mode the piece counter never passes the second piece.
  AST_WIDE_CNT_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (busWide && !cfgChange) |-> (txCnt <= WIDE_LAST && rxCnt <= WIDE_LAST)); // R5

  // A waiting piece keeps its slot until taken.
  AST_TX_WAIT_IDX: assert property (@(posedge clk) disable iff (!rstN)
    ($past(outFull) && !$past(txReady) && !$past(cfgChange) && !cfgChange)
      |-> (outFull && $stable(txCnt))); // R6

endmodule

// File: rtl/pport_datapath.sv
module pport_datapath
  import pport_pkg::*;
#(
  parameter int WORD_W        = 32,
  parameter int BUS_W         = 16,
  parameter int NARROW_W      = 8,
  parameter int NARROW_PIECES = 4,
  parameter int WIDE_PIECES   = 2,
  parameter int CNT_W         = 2,
  parameter int WIDX_W        = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          strobe,
  input  logic              busWide,
  input  logic [CNT_W-1:0]  txIdx,
  input  logic [CNT_W-1:0]  rxIdx,
  input  logic [WORD_W-1:0] wrData,
  input  logic [BUS_W-1:0]  rxData,
  output logic [BUS_W-1:0]  txData,
  output logic [WORD_W-1:0] rdData
);

  logic [WORD_W-1:0]   holdReg, outReg, rxAcc, nextAcc;
  logic [NARROW_W-1:0] narrowPiece [NARROW_PIECES];
  logic [BUS_W-1:0]    widePiece   [WIDE_PIECES];

  // Slice the output register into bus pieces, lowest piece at index 0.
  for (genvar i = 0; i < NARROW_PIECES; i++) begin : g_narrow
    assign narrowPiece[i] = outReg[i*NARROW_W +: NARROW_W];
  end
  for (genvar j = 0; j < WIDE_PIECES; j++) begin : g_wide
    assign widePiece[j] = outReg[j*BUS_W +: BUS_W];
  end

  assign txData = busWide ? widePiece[txIdx[WIDX_W-1:0]]
                          : {{(BUS_W-NARROW_W){1'b0}}, narrowPiece[txIdx]};

  // Merge the incoming piece into its slot of the packer.
  always_comb begin
    nextAcc = rxAcc;
    if (busWide) begin
      for (int k = 0; k < WIDE_PIECES; k++)
        if (rxIdx == CNT_W'(k)) nextAcc[k*BUS_W +: BUS_W] = rxData;
    end else begin
      for (int k = 0; k < NARROW_PIECES; k++)
        if (rxIdx == CNT_W'(k)) nextAcc[k*NARROW_W +: NARROW_W] = rxData[NARROW_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdReg <= '0;
      outReg  <= '0;
      rxAcc   <= '0;
      rdData  <= '0;
    end else if (strobe.clear) begin
      holdReg <= '0;
      outReg  <= '0;
      rxAcc   <= '0;
    end else begin
      if (strobe.loadHold) holdReg <= wrData;
      if (strobe.moveOut)  outReg  <= holdReg;
      if (strobe.rxLoad)   rxAcc   <= nextAcc;
      if (strobe.rxDone)   rdData  <= nextAcc;
    end
  end

  // The holding word is kept until it is moved or replaced by an accepted write.
  AST_HOLD_KEPT: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.loadHold && !strobe.clear) |=> $stable(holdReg)); // R8

endmodule

// File: rtl/pport_pack_buffer.sv
module pport_pack_buffer
  import pport_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int BUS_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWide,
  input  logic              txEnable,
  input  logic              wrValid,
  input  logic [WORD_W-1:0] wrData,
  output logic              wrReady,
  output logic              txValid,
  output logic [BUS_W-1:0]  txData,
  input  logic              txReady,
  input  logic              rxValid,
  input  logic [BUS_W-1:0]  rxData,
  output logic              rdValid,
  output logic [WORD_W-1:0] rdData,
  output logic              holdEmpty,
  output logic              outEmpty
);

  localparam int NARROW_W      = BUS_W / 2;
  localparam int NARROW_PIECES = WORD_W / NARROW_W;
  localparam int WIDE_PIECES   = WORD_W / BUS_W;
  localparam int CNT_W         = $clog2(NARROW_PIECES);
  localparam int WIDX_W        = $clog2(WIDE_PIECES);

  strobes_t         strobe;
  logic [CNT_W-1:0] txIdx, rxIdx;

  pport_ctrl #(
    .NARROW_PIECES(NARROW_PIECES),
    .WIDE_PIECES  (WIDE_PIECES),
    .CNT_W        (CNT_W)
  ) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .busWide  (busWide),
    .txEnable (txEnable),
    .wrValid  (wrValid),
    .txReady  (txReady),
    .rxValid  (rxValid),
    .wrReady  (wrReady),
    .txValid  (txValid),
    .rdValid  (rdValid),
    .holdEmpty(holdEmpty),
    .outEmpty (outEmpty),
    .txIdx    (txIdx),
    .rxIdx    (rxIdx),
    .strobe   (strobe)
  );

  pport_datapath #(
    .WORD_W       (WORD_W),
    .BUS_W        (BUS_W),
    .NARROW_W     (NARROW_W),
    .NARROW_PIECES(NARROW_PIECES),
    .WIDE_PIECES  (WIDE_PIECES),
    .CNT_W        (CNT_W),
    .WIDX_W       (WIDX_W)
  ) data_i (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .busWide(busWide),
    .txIdx  (txIdx),
    .rxIdx  (rxIdx),
    .wrData (wrData),
    .rxData (rxData),
    .txData (txData),
    .rdData (rdData)
  );

  AST_NO_WRITE_WHEN_FULL: assert property (@(posedge clk) disable iff (!rstN)
    !holdEmpty |-> !wrReady); // R8

  AST_RDVALID_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |=> !rdValid); // R3

  AST_DISABLED_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    (!txEnable && $past(!txEnable)) |-> (holdEmpty && outEmpty && !txValid)); // R10

  AST_TX_DATA_HELD: assert property (@(posedge clk) disable iff (!rstN)
    ($past(txValid) && !$past(txReady) && $stable(busWide) && $stable(txEnable)
      && $past(busWide) == $past(busWide, 2) && $past(txEnable) == $past(txEnable, 2))
      |-> (txValid && $stable(txData))); // R6

endmodule

// File: tb/pport_pack_buffer_tb_top.sv
module pport_pack_buffer_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWide = 1'b0, txEnable = 1'b0;
  logic        wrValid = 1'b0, txReady = 1'b0, rxValid = 1'b0;
  logic [31:0] wrData = '0;
  logic [15:0] rxData = '0;
  logic        wrReady, txValid, rdValid, holdEmpty, outEmpty;
  logic [15:0] txData;
  logic [31:0] rdData;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;  // 250 MHz

  pport_pack_buffer dut_i (
    .clk(clk), .rstN(rstN), .busWide(busWide), .txEnable(txEnable),
    .wrValid(wrValid), .wrData(wrData), .wrReady(wrReady),
    .txValid(txValid), .txData(txData), .txReady(txReady),
    .rxValid(rxValid), .rxData(rxData), .rdValid(rdValid), .rdData(rdData),
    .holdEmpty(holdEmpty), .outEmpty(outEmpty)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  // Change settings and let the one flush cycle pass.
  task automatic configure(logic wide, logic en);
    busWide  = wide;
    txEnable = en;
    step();
  endtask

  task automatic rxWord(logic wide, logic [31:0] w, string req);
    int n = wide ? 2 : 4;
    int pw = wide ? 16 : 8;
    for (int i = 0; i < n; i++) begin
      rxValid = 1'b1;
      rxData  = wide ? w[i*16 +: 16] : {8'h00, w[i*8 +: 8]};
      step();
      if (i < n - 1) check({req, " no early rdValid"}, rdValid, 1'b0);
    end
    rxValid = 1'b0;
    check({req, " rdValid"}, rdValid, 1'b1);
    check({req, " rdData"}, rdData, w);
    step();
    check("R3 pulse ends", rdValid, 1'b0);
    if (pw == 0) check("unused", 0, 1);
  endtask

  task automatic test_reset();
    check("R12 holdEmpty", holdEmpty, 1'b1);
    check("R12 outEmpty", outEmpty, 1'b1);
    check("R12 txValid", txValid, 1'b0);
    check("R12 rdValid", rdValid, 1'b0);
    check("R12 wrReady", wrReady, 1'b0);
  endtask

  task automatic test_rx();
    configure(1'b0, 1'b0);
    rxWord(1'b0, 32'h44332211, "R1");
    // gapped pieces, new word starts at the lowest piece
    rxValid = 1'b1; rxData = 16'h00A1; step();
    rxValid = 1'b0; step(); step();
    rxValid = 1'b1; rxData = 16'h00B2; step();
    rxData = 16'h00C3; step();
    rxValid = 1'b0; step();
    rxValid = 1'b1; rxData = 16'h00D4; step();
    rxValid = 1'b0;
    check("R3 gapped rdValid", rdValid, 1'b1);
    check("R3 gapped word", rdData, 32'hD4C3B2A1);
    step();
    configure(1'b1, 1'b0);
    rxWord(1'b1, 32'h5678_1234, "R2");
    rxWord(1'b1, 32'hCAFE_F00D, "R2 second word");
  endtask

  // Drain one word, check each piece and the spacing.
  task automatic drainWord(logic wide, logic [31:0] w, string req);
    int n = wide ? 2 : 4;
    for (int i = 0; i < n; i++) begin
      txReady = 1'b1;
      check({req, " txValid"}, txValid, 1'b1);
      check({req, " piece"}, txData,
            wide ? w[i*16 +: 16] : {8'h00, w[i*8 +: 8]});
      step();
    end
    txReady = 1'b0;
  endtask

  task automatic test_tx_basic();
    configure(1'b0, 1'b1);
    wrValid = 1'b1; wrData = 32'hDEADBEEF;
    #1 check("R7 wrReady empty", wrReady, 1'b1);
    step();
    wrValid = 1'b0;
    check("R7 holdEmpty after accept", holdEmpty, 1'b0);
    check("R7 outEmpty after accept", outEmpty, 1'b1);
    step();
    check("R7 holdEmpty after move", holdEmpty, 1'b1);
    check("R7 outEmpty after move", outEmpty, 1'b0);
    // hold with txReady low
    for (int i = 0; i < 3; i++) begin
      check("R6 held piece", txData, 32'h000000EF);
      check("R6 held valid", txValid, 1'b1);
      step();
    end
    drainWord(1'b0, 32'hDEADBEEF, "R4");
    check("R4 empty after drain", txValid, 1'b0);
    configure(1'b1, 1'b1);
    wrValid = 1'b1; wrData = 32'h89AB4567;
    step(); wrValid = 1'b0; step();
    drainWord(1'b1, 32'h89AB4567, "R5");
    check("R5 empty after drain", outEmpty, 1'b1);
  endtask

  task automatic test_stream();
    logic [31:0] words [3] = '{32'h11223344, 32'h55667788, 32'h99AABBCC};
    logic [7:0] expQ [12];
    int got = 0, cycles = 0, firstCycle = -1, wIdx = 0;
    for (int w = 0; w < 3; w++)
      for (int p = 0; p < 4; p++) expQ[w*4+p] = words[w][p*8 +: 8];
    configure(1'b0, 1'b1);
    // A then B: B stalls one cycle while A sits in hold
    wrValid = 1'b1; wrData = words[0]; step();
    wrData = words[1];
    #1 check("R8 stall while hold full", wrReady, 1'b0);
    step();
    #1 check("R8 ready after move", wrReady, 1'b1);
    step();
    // C: both stages full, txReady low -> stalled
    wrData = words[2];
    for (int i = 0; i < 3; i++) begin
      #1 check("R8 stall both full", wrReady, 1'b0);
      check("R8 hold occupied", holdEmpty, 1'b0);
      step();
    end
    wIdx = 2;
    txReady = 1'b1;
    while (got < 12 && cycles < 40) begin
      #1;
      if (txValid) begin
        if (firstCycle < 0) firstCycle = cycles;
        check("R9 stream piece", txData, {24'h0, expQ[got]});
        got++;
      end
      if (wrValid && wrReady) begin
        step();
        wrValid = 1'b0;
      end else begin
        step();
      end
      cycles++;
    end
    txReady = 1'b0;
    check("R8 no word lost", got, 12);
    check("R9 no idle cycle", cycles - firstCycle, 12);
    check("R9 drained", outEmpty, 1'b1);
    if (wIdx != 2) check("unused", 0, 1);
  endtask

  task automatic test_disabled();
    configure(1'b0, 1'b0);
    wrValid = 1'b1; wrData = 32'h0BADF00D;
    for (int i = 0; i < 4; i++) begin
      #1 check("R10 wrReady low", wrReady, 1'b0);
      step();
    end
    wrValid = 1'b0;
    check("R10 holdEmpty", holdEmpty, 1'b1);
    check("R10 outEmpty", outEmpty, 1'b1);
    check("R10 txValid", txValid, 1'b0);
  endtask

  task automatic test_flush();
    // partial rx in 8-bit mode, then switch to 16-bit
    configure(1'b0, 1'b0);
    rxValid = 1'b1; rxData = 16'h0077; step();
    rxData = 16'h0066; step();
    rxValid = 1'b0;
    busWide = 1'b1;
    #1 check("R11 no write in change cycle", wrReady, 1'b0);
    step();
    rxWord(1'b1, 32'hBBBBAAAA, "R11 packer cleared");
    // partial tx, then width change
    configure(1'b1, 1'b1);
    wrValid = 1'b1; wrData = 32'h12345678; step();
    wrData = 32'h9ABCDEF0; step();
    step();
    wrValid = 1'b0;
    txReady = 1'b1; step(); txReady = 1'b0;
    busWide = 1'b0; step();
    check("R11 hold cleared", holdEmpty, 1'b1);
    check("R11 out cleared", outEmpty, 1'b1);
    check("R11 txValid cleared", txValid, 1'b0);
    // counter restarts at lowest piece
    wrValid = 1'b1; wrData = 32'hA1B2C3D4; step(); wrValid = 1'b0; step();
    drainWord(1'b0, 32'hA1B2C3D4, "R11 counter reset");
  endtask

  initial begin
    repeat (3) step();
    rstN = 1'b1;
    step();
    test_reset();
    test_rx();
    test_tx_basic();
    test_stream();
    test_disabled();
    test_flush();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule